// File: doc/BRIEF.md
# Pulse-Swallow Dual-Modulus Feedback Divider

This block divides a fast input clock by a programmable ratio N = P·B + A and emits one pulse, one input clock wide, every N input cycles. It is meant to close the feedback path of a frequency synthesizer loop, with the pulse going to the phase comparator. P is the base modulus of an internal dual-modulus prescaler and is either 8 or 32. The prescaler divides by P or by P+1, and each of its output periods clocks a main count of B and a swallow count of A.

The prescaler is built around a synchronous divide-by-4/5 core. A group counter runs the core P/4 times per prescaler period. When the swallow count is still nonzero, the core stretches its last pass by one input cycle. The first A prescaler periods of each output cycle therefore last P+1 cycles and the remaining B−A periods last P cycles. Because of this, the ratio moves in steps of one input cycle.

New settings are taken only on the cycle that ends an output period. A settings word applied in mid-period therefore never shortens or stretches the period in progress. If the block takes a swallow count larger than the main count, or a main count below 3, it raises a sticky error flag. Only reset clears that flag.

Top module: `pulse_swallow_div`

## Requirements
- R1: With mode_32 = 0 (P = 8) and legal settings (3 ≤ B, A ≤ B), successive rising edges of div_out are exactly 8·B + A input cycles apart.
- R2: With mode_32 = 1 (P = 32) and legal settings, successive rising edges of div_out are exactly 32·B + A input cycles apart.
- R3: With A = 0 the prescaler never swallows, and the ratio is exactly P·B in either mode.
- R4: div_out is high for exactly one input clock per output period.
- R5: b_val, a_val and mode_32 are sampled only on the clock edge that raises div_out. The output period running when they change keeps its old length, and the following period has the new length.
- R6: Taking a setting with A > B sets cfg_err on the same edge that raises div_out. Before that edge, the pending setting leaves cfg_err low.
- R7: Taking a setting with B < 3 sets cfg_err on the edge that raises div_out.
- R8: cfg_err stays high after legal settings return, and only rst clears it.
- R9: While rst is high (synchronous, active high), div_out and cfg_err are low. The settings present during reset form the first output period.
- R10: At the boundary A = B, every prescaler period of the output cycle runs at P+1, and the ratio is (P+1)·B.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast input clock to be divided |
| rst | input | 1 | Synchronous reset, active high |
| b_val | input | 13 | Main count B (legal 3..8191) |
| a_val | input | 5 | Swallow count A (0..31, must not exceed B) |
| mode_32 | input | 1 | 0 selects P = 8 (8/9), 1 selects P = 32 (32/33) |
| div_out | output | 1 | One-clock pulse per N input cycles |
| cfg_err | output | 1 | Sticky flag for an illegal setting taken at a reload |

## Verification
The hardest condition to reach is a settings change that lands in the middle of an output period. It must leave that period intact and govern only the next one. The stimulus always writes new settings just after a pulse. It then measures two intervals back to back: the first must match the old ratio and the second the new one. The same timing shows that an illegal A > B setting leaves cfg_err low until the next boundary edge, and that the flag then rises together with the pulse.

// File: rtl/pulse_swallow_div.sv
module pulse_swallow_div #(
  parameter int BW   = 13,
  parameter int AW   = 5,
  parameter int BMIN = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [BW-1:0] b_val,
  input  logic [AW-1:0] a_val,
  input  logic          mode_32,
  output logic          div_out,
  output logic          cfg_err
);
  localparam int KW = 3;
  localparam logic [KW-1:0] GRP_LAST_8  = KW'(1);
  localparam logic [KW-1:0] GRP_LAST_32 = KW'(7);

  logic [2:0]    core;
  logic [KW-1:0] grp;
  logic [AW-1:0] a_cnt;
  logic [BW-1:0] b_cnt;
  logic          mode_r;

  logic [KW-1:0] grp_last;
  logic          mc, last_grp, swallow, core_end, pre_tc, term, bad_in;

  assign grp_last = mode_r ? GRP_LAST_32 : GRP_LAST_8;
  assign mc       = (a_cnt != '0);
  assign last_grp = (grp == grp_last);
  assign swallow  = mc & last_grp;
  assign core_end = (core == (swallow ? 3'd4 : 3'd3));
  assign pre_tc   = core_end & last_grp;
  assign term     = pre_tc & (b_cnt <= BW'(1));
  assign bad_in   = (BW'(a_val) > b_val) | (b_val < BW'(BMIN));

  always_ff @(posedge clk) begin
    if (rst) begin
      core    <= '0;
      grp     <= '0;
      a_cnt   <= a_val;
      b_cnt   <= b_val;
      mode_r  <= mode_32;
      div_out <= 1'b0;
      cfg_err <= 1'b0;
    end else begin
      div_out <= term;
      core    <= core_end ? 3'd0 : core + 3'd1;
      if (core_end)
        grp <= last_grp ? '0 : grp + KW'(1);
      if (term) begin
        a_cnt   <= a_val;
        b_cnt   <= b_val;
        mode_r  <= mode_32;
        cfg_err <= cfg_err | bad_in;
      end else if (pre_tc) begin
        b_cnt <= b_cnt - BW'(1);
        if (mc)
          a_cnt <= a_cnt - AW'(1);
      end
    end
  end

  // R4
  pulse_width_chk: assert property (@(posedge clk) disable iff (rst)
    div_out |=> !div_out);

  // R8
  sticky_err_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_err |=> cfg_err);

  // R5
  cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !term |=> $stable(mode_r));

  // R1
  b_step_chk: assert property (@(posedge clk) disable iff (rst)
    (pre_tc && !term) |=> (b_cnt == $past(b_cnt) - BW'(1)));

  // R10
  a_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!term && !(pre_tc && mc)) |=> $stable(a_cnt));

  // R3
  core_range_chk: assert property (@(posedge clk) disable iff (rst)
    core <= 3'd4);
endmodule

// File: tb/test_pulse_swallow_div.sv
module test_pulse_swallow_div;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [12:0] b_val = 13'd4;
  logic [4:0]  a_val = 5'd2;
  logic        mode_32 = 1'b0;
  logic        div_out, cfg_err;
  int          cyc = 0;
  int          total = 0;
  int          bad = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pulse_swallow_div i_pulse_swallow_div (
    .clk(clk), .rst(rst), .b_val(b_val), .a_val(a_val),
    .mode_32(mode_32), .div_out(div_out), .cfg_err(cfg_err));

  // {mode, B, A, expected N}
  localparam int NV = 8;
  localparam logic [50:0] VEC [NV] = '{
    {1'b0, 13'd3,   5'd0,  32'd24},
    {1'b0, 13'd10,  5'd3,  32'd83},
    {1'b0, 13'd5,   5'd5,  32'd45},
    {1'b1, 13'd3,   5'd1,  32'd97},
    {1'b1, 13'd40,  5'd31, 32'd1311},
    {1'b1, 13'd20,  5'd0,  32'd640},
    {1'b0, 13'd100, 5'd31, 32'd831},
    {1'b1, 13'd31,  5'd31, 32'd1023}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_pulse(output int t);
    int n = 0;
    t = -1;
    while (n < 6000) begin
      @(negedge clk);
      n++;
      if (div_out) begin
        t = cyc;
        @(negedge clk);
        chk(!div_out, "R4 pulse width", int'(div_out), 0);
        return;
      end
    end
    chk(1'b0, "watchdog no pulse", 0, 1);
  endtask

  task automatic reset_dut();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk(!div_out, "R9 div_out in reset", int'(div_out), 0);
    chk(!cfg_err, "R9 cfg_err in reset", int'(cfg_err), 0);
    rst = 1'b0;
  endtask

  initial begin
    int t0, t1, t2, prev_n;
    repeat (4) @(negedge clk);
    chk(!div_out, "R9 div_out in reset", int'(div_out), 0);
    chk(!cfg_err, "R9 cfg_err in reset", int'(cfg_err), 0);
    rst = 1'b0;
    wait_pulse(t0);
    prev_n = 34;
    for (int i = 0; i < NV; i++) begin
      int exp_n;
      string tag;
      mode_32 = VEC[i][50];
      b_val   = VEC[i][49:37];
      a_val   = VEC[i][36:32];
      exp_n   = int'(VEC[i][31:0]);
      tag = mode_32 ? "R2 ratio P=32" : "R1 ratio P=8";
      if (a_val == 0) tag = {tag, " R3 A=0"};
      if (a_val == b_val[4:0] && b_val < 32) tag = {tag, " R10 A=B"};
      wait_pulse(t1);
      chk(t1 - t0 == prev_n, "R5 old period kept", t1 - t0, prev_n);
      wait_pulse(t2);
      chk(t2 - t1 == exp_n, tag, t2 - t1, exp_n);
      chk(!cfg_err, "R6 no error on legal setting", int'(cfg_err), 0);
      t0 = t2;
      prev_n = exp_n;
    end

    // R6: A > B pending has no effect until the boundary
    mode_32 = 1'b0; b_val = 13'd5; a_val = 5'd9;
    repeat (5) @(negedge clk);
    chk(!cfg_err, "R6 flag before boundary", int'(cfg_err), 0);
    begin
      int n = 0;
      while (!div_out && n < 6000) begin @(negedge clk); n++; end
    end
    chk(div_out && cfg_err, "R6 flag with pulse", int'(cfg_err), 1);

    // R9 / R8: reset clears
    b_val = 13'd4; a_val = 5'd1;
    reset_dut();
    @(negedge clk);
    chk(!cfg_err, "R8 reset clears flag", int'(cfg_err), 0);

    // R7: B below minimum
    b_val = 13'd2; a_val = 5'd0;
    wait_pulse(t0);
    wait_pulse(t1);
    chk(cfg_err, "R7 B<3 flag", int'(cfg_err), 1);

    // R8: sticky after legal values return
    b_val = 13'd4; a_val = 5'd1;
    wait_pulse(t0);
    wait_pulse(t1);
    chk(cfg_err, "R8 flag sticky", int'(cfg_err), 1);
    chk(t1 - t0 == 33, "R1 ratio after error", t1 - t0, 33);
    reset_dut();
    @(negedge clk);
    chk(!cfg_err, "R8 cleared by reset", int'(cfg_err), 0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 150000, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule